// File: doc/BRIEF.md
# Synchronous FIFO with Status Flags

A single-clock first-in first-out buffer built around an internal RAM array. Writes are accepted while the buffer has room and reads while it holds data. A full set of status flags is kept in registers that update on the same clock edge as the occupancy change they describe: empty, almost-empty, full and almost-full. Two error strobes report requests that the buffer refused. The almost thresholds are set by offset parameters.

A parameter selects the read mode. In standard mode a word is presented on the output one clock after an accepted read request. In first-word-fall-through mode the oldest word is moved to the output by itself, and a read request consumes it. Reset is synchronous and active high.

Top module: `sync_fifo_flags`

## Requirements
- R1: While reset is high at a clock edge, the edge sets empty=1, almostEmpty=1, full=0, almostFull=0, wrErr=0, rdErr=0 and rdData=0.
- R2: In standard mode, an accepted read loads the oldest stored word onto rdData at the same clock edge. rdData holds its value at every edge with no accepted read. Words leave in the order they were written.
- R3: In fall-through mode, a word written into an empty FIFO appears on rdData with empty=0 by the second clock edge after the write, with no read request. An accepted read replaces it with the next stored word, or raises empty if none is left.
- R4: full rises at the clock edge that writes the entry that brings the occupancy to DEPTH, with no further delay.
- R5: A write request while full=1 stores nothing and does not change the pointers. If a read is requested in the same cycle, only the read is performed.
- R6: A read request while empty=1 does not change rdData, the occupancy or the flags.
- R7: wrErr is high for exactly one cycle, following the edge at which a write was requested while full=1.
- R8: rdErr is high for exactly one cycle, following the edge at which a read was requested while empty=1.
- R9: almostFull is 1 exactly when the occupancy is at least DEPTH-AFULL_OFS. almostEmpty is 1 exactly when the occupancy is at most AEMPTY_OFS.
- R10: A read and a write in the same cycle, while neither empty nor full, leave the occupancy and all flags unchanged and keep the data order.
- R11: A reset asserted during operation empties the FIFO at the next clock edge, and the stored data is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrReq | input | 1 | Write request |
| wrData | input | DATA_W | Data to write |
| rdReq | input | 1 | Read request (consume request in fall-through mode) |
| rdData | output | DATA_W | Output data |
| empty | output | 1 | No word available for reading |
| almostEmpty | output | 1 | Occupancy at or below AEMPTY_OFS |
| full | output | 1 | Occupancy equals DEPTH |
| almostFull | output | 1 | Occupancy at or above DEPTH-AFULL_OFS |
| wrErr | output | 1 | One-cycle pulse after a refused write |
| rdErr | output | 1 | One-cycle pulse after a refused read |

## Verification
The hardest case to reach is a write and a read requested together while the buffer is exactly full. Here the write must be refused and flagged, the read must be honoured, and no entry may be lost or duplicated. The stimulus fills the buffer with exactly DEPTH numbered words and pushes a marker word into the full buffer. It then issues a combined request and drains the rest, checking each word in turn. This confirms that the marker never shows up. The fall-through instance is driven separately so that its prefetch runs while a read is taking a word in the same cycle.

// File: rtl/fifo_flags_pkg.sv
package fifo_flags_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic write;   // store wrData at the write pointer, advance it
    logic fetch;   // load the output register from the read pointer, advance it
  } fifoStrobe_t;
endpackage

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_flags_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [DATA_W-1:0] doutR;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (strobe.write) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      doutR <= '0;
    end else begin
      if (strobe.write) wrPtr <= bump(wrPtr);
      if (strobe.fetch) begin
        doutR <= mem[rdPtr];
        rdPtr <= bump(rdPtr);
      end
    end
  end

  assign rdData = doutR;

  // R5: write pointer moves only on an accepted write
  p_wrptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe.write |=> $stable(wrPtr));
  // R6: read pointer and output move only on a fetch
  p_rdptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe.fetch |=> ($stable(rdPtr) && $stable(doutR)));
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_flags_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int AFULL_OFS  = 2,
  parameter int AEMPTY_OFS = 2,
  parameter bit FWFT_MODE  = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrReq,
  input  logic        rdReq,
  output fifoStrobe_t strobe,
  output logic        empty,
  output logic        almostEmpty,
  output logic        full,
  output logic        almostFull,
  output logic        wrErr,
  output logic        rdErr
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int AF_LVL = DEPTH - AFULL_OFS;

  logic [CW-1:0] occ, occNext;
  logic          wrAcc, rdAcc, fetch, emptyVis;

  assign wrAcc = wrReq && !full;
  assign rdAcc = rdReq && !emptyVis;

  always_comb begin
    occNext = occ;
    if (wrAcc && !rdAcc)      occNext = occ + CW'(1);
    else if (rdAcc && !wrAcc) occNext = occ - CW'(1);
  end

  generate
    if (FWFT_MODE) begin : g_fwft
      // output register counts as one occupied entry
      logic          outValid;
      logic [CW-1:0] ramCount;
      assign ramCount = occ - CW'(outValid);
      assign fetch    = (ramCount != '0) && (!outValid || rdAcc);
      always_ff @(posedge clk) begin
        if (rst)        outValid <= 1'b0;
        else if (fetch) outValid <= 1'b1;
        else if (rdAcc) outValid <= 1'b0;
      end
      assign emptyVis = !outValid;

      // R3: a presented word stays until it is consumed
      p_fwft_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (outValid && !rdReq) |=> outValid);
    end else begin : g_std
      logic emptyR;
      always_ff @(posedge clk) begin
        if (rst) emptyR <= 1'b1;
        else     emptyR <= (occNext == '0);
      end
      assign fetch    = rdAcc;
      assign emptyVis = emptyR;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      occ         <= '0;
      full        <= 1'b0;
      almostFull  <= 1'b0;
      almostEmpty <= 1'b1;
      wrErr       <= 1'b0;
      rdErr       <= 1'b0;
    end else begin
      occ         <= occNext;
      full        <= (occNext == CW'(DEPTH));
      almostFull  <= (occNext >= CW'(AF_LVL));
      almostEmpty <= (occNext <= CW'(AEMPTY_OFS));
      wrErr       <= wrReq && full;
      rdErr       <= rdReq && emptyVis;
    end
  end

  assign empty        = emptyVis;
  assign strobe.write = wrAcc;
  assign strobe.fetch = fetch;

  // R5: occupancy never exceeds the array size
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));
  // R5: a write into a full FIFO alone changes nothing
  p_full_wr_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (full && wrReq && !rdReq) |=> $stable(occ));
  // R6: a read from an empty FIFO alone changes nothing
  p_empty_rd_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (emptyVis && rdReq && !wrReq) |=> $stable(occ));
  // R4: full follows the last free entry with no delay
  p_full_now_r4: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(DEPTH - 1) && wrReq && !rdReq) |=> full);
  // R7: refused write is reported
  p_wr_err_r7: assert property (@(posedge clk) disable iff (rst)
    (full && wrReq) |=> wrErr);
  // R8: refused read is reported
  p_rd_err_r8: assert property (@(posedge clk) disable iff (rst)
    (emptyVis && rdReq) |=> rdErr);
  // R10: balanced traffic keeps the occupancy
  p_balance_r10: assert property (@(posedge clk) disable iff (rst)
    (!emptyVis && !full && wrReq && rdReq) |=> $stable(occ));
endmodule

// File: rtl/sync_fifo_flags.sv
module sync_fifo_flags
  import fifo_flags_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 16,
  parameter int AFULL_OFS  = 2,
  parameter int AEMPTY_OFS = 2,
  parameter bit FWFT_MODE  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty,
  output logic              full,
  output logic              almostFull,
  output logic              wrErr,
  output logic              rdErr
);
  fifoStrobe_t strobe;

  fifo_ctrl #(
    .DEPTH(DEPTH), .AFULL_OFS(AFULL_OFS),
    .AEMPTY_OFS(AEMPTY_OFS), .FWFT_MODE(FWFT_MODE)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq), .strobe(strobe),
    .empty(empty), .almostEmpty(almostEmpty), .full(full),
    .almostFull(almostFull), .wrErr(wrErr), .rdErr(rdErr)
  );

  fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );

  // R1/R9: full and empty are never reported together
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
endmodule

// File: tb/sync_fifo_flags_tb_top.sv
module sync_fifo_flags_tb_top;
  localparam int DW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic wrS = 0, rdS = 0, wrF = 0, rdF = 0;
  logic [DW-1:0] dinS = '0, dinF = '0, doutS, doutF;
  logic eS, aeS, fS, afS, weS, reS;
  logic eF, aeF, fF, afF, weF, reF;

  int checks = 0;
  int errors = 0;

  sync_fifo_flags #(.DATA_W(DW), .DEPTH(DEPTH), .AFULL_OFS(2), .AEMPTY_OFS(2), .FWFT_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .wrReq(wrS), .wrData(dinS), .rdReq(rdS), .rdData(doutS),
    .empty(eS), .almostEmpty(aeS), .full(fS), .almostFull(afS), .wrErr(weS), .rdErr(reS));

  sync_fifo_flags #(.DATA_W(DW), .DEPTH(DEPTH), .AFULL_OFS(2), .AEMPTY_OFS(2), .FWFT_MODE(1'b1)) dutFwft_i (
    .clk(clk), .rst(rst), .wrReq(wrF), .wrData(dinF), .rdReq(rdF), .rdData(doutF),
    .empty(eF), .almostEmpty(aeF), .full(fF), .almostFull(afF), .wrErr(weF), .rdErr(reF));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle on the standard instance; returns after the edge
  task automatic stepS(input logic w, input logic r, input logic [DW-1:0] d);
    @(negedge clk); wrS = w; rdS = r; dinS = d;
    @(posedge clk); #2;
  endtask
  task automatic stepF(input logic w, input logic r, input logic [DW-1:0] d);
    @(negedge clk); wrF = w; rdF = r; dinF = d;
    @(posedge clk); #2;
  endtask

  typedef struct packed {
    logic wr; logic rd; logic [DW-1:0] din;
    logic eE; logic eAe; logic eAf; logic eF; logic eWe; logic eRe;
    logic [DW-1:0] eD;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00}, // R8 R6 read empty
    '{1'b1,1'b0,8'h11, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00},
    '{1'b1,1'b0,8'h22, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00},
    '{1'b1,1'b0,8'h33, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00}, // R9 occ 3
    '{1'b1,1'b1,8'h44, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h11}, // R10 R2
    '{1'b0,1'b1,8'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h22},
    '{1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h22}, // R2 hold
    '{1'b0,1'b1,8'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h33},
    '{1'b0,1'b1,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h44},
    '{1'b0,1'b1,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h44}, // R6 R8
    '{1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'h44}  // R8 one-cycle
  };

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state on both instances
    repeat (3) @(posedge clk);
    #2;
    check("R1", "empty", eS, 1); check("R1", "almostEmpty", aeS, 1);
    check("R1", "full", fS, 0);  check("R1", "almostFull", afS, 0);
    check("R1", "wrErr", weS, 0); check("R1", "rdErr", reS, 0);
    check("R1", "rdData", doutS, 0);
    check("R1", "fwft empty", eF, 1); check("R1", "fwft rdData", doutF, 0);
    @(negedge clk); rst = 0;

    // vector table: R2 R6 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      stepS(VECS[i].wr, VECS[i].rd, VECS[i].din);
      check("R2/R6/R8/R9/R10 table", "empty", eS, VECS[i].eE);
      check("R9 table", "almostEmpty", aeS, VECS[i].eAe);
      check("R9 table", "almostFull", afS, VECS[i].eAf);
      check("R4 table", "full", fS, VECS[i].eF);
      check("R7 table", "wrErr", weS, VECS[i].eWe);
      check("R8 table", "rdErr", reS, VECS[i].eRe);
      check("R2 table", "rdData", doutS, VECS[i].eD);
    end

    // fill to exactly DEPTH: R4 R9
    for (int i = 0; i < DEPTH; i++) begin
      stepS(1, 0, DW'(8'hA0 + i));
      check("R4", "full during fill", fS, (i + 1 == DEPTH));
      check("R9", "almostFull during fill", afS, (i + 1 >= DEPTH - 2));
      check("R9", "almostEmpty during fill", aeS, (i + 1 <= 2));
    end
    // R5 R7 write into full
    stepS(1, 0, 8'h5A);
    check("R7", "wrErr after refused write", weS, 1);
    check("R5", "full stays", fS, 1);
    stepS(0, 0, 8'h00);
    check("R7", "wrErr single cycle", weS, 0);
    // R5 combined request while full: read only
    stepS(1, 1, 8'h5B);
    check("R5", "full after combined", fS, 0);
    check("R7", "wrErr combined", weS, 1);
    check("R2", "first word out", doutS, 8'hA0);
    for (int i = 1; i < DEPTH; i++) begin
      stepS(0, 1, 8'h00);
      check("R5 R2", "drain order", doutS, DW'(8'hA0 + i));
    end
    check("R5", "empty after drain", eS, 1);
    stepS(0, 1, 8'h00);
    check("R5 R6", "no extra word", doutS, 8'hAF);
    check("R8", "rdErr after drain", reS, 1);

    // R11 reset mid-operation
    stepS(1, 0, 8'h61);
    stepS(1, 0, 8'h62);
    @(negedge clk); wrS = 0; rst = 1;
    @(posedge clk); #2;
    check("R11", "empty after reset", eS, 1);
    check("R11", "rdData after reset", doutS, 0);
    check("R11", "almostEmpty after reset", aeS, 1);
    @(negedge clk); rst = 0;
    stepS(0, 1, 8'h00);
    check("R11", "data lost, read refused", reS, 1);
    check("R11", "rdData unchanged", doutS, 0);
    stepS(0, 0, 8'h00);

    // R3 fall-through instance
    stepF(1, 0, 8'h77);
    stepF(1, 0, 8'h88);
    check("R3", "first word falls through", doutF, 8'h77);
    check("R3", "empty low without read", eF, 0);
    stepF(0, 0, 8'h00);
    check("R3", "word held", doutF, 8'h77);
    stepF(0, 1, 8'h00);
    check("R3", "next word after read", doutF, 8'h88);
    check("R3", "still not empty", eF, 0);
    stepF(0, 1, 8'h00);
    check("R3", "empty after last", eF, 1);
    stepF(0, 1, 8'h00);
    check("R8", "fwft rdErr", reF, 1);
    check("R6", "fwft rdData unchanged", doutF, 8'h88);
    stepF(0, 0, 8'h00);
    check("R8", "fwft rdErr single", reF, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule